// File: doc/BRIEF.md
# Two-Way Intersection Signal Sequencer

This block sequences the lamps of a crossing where two roads share one junction. A 3-bit phase register moves one step on every clock edge through six phases: an all-red clearance, green then yellow for the first road, a second all-red clearance, then green and yellow for the second road. Each phase lasts exactly one clock cycle; a slower enable or a timer is the caller's concern.

The lamp outputs are a Moore function of the phase code. The code is decoded to one line per value, and the red lamps come from OR-ing the decoded lines of the phases in which each road must stop. A single request input forces a seventh phase, code 110, in which both roads see red. The sequencer stays there while the request is held and falls back to the all-red phase 000 once it is released. The unused code 111 also shows all red and leaves on the next edge.

Top module: `tl_intersection_ctrl`

## Requirements
- R1: A synchronous active-high reset loads phase 000. In that phase only both red lamps are lit.
- R2: With the request low, the phase output steps 000, 001, 010, 011, 100, 101 and back to 000, one step per rising clock edge. The phase bits are the binary code, with bit 2 the most significant.
- R3: In phase 001 only road-1 green and road-2 red are lit. In 010 only road-1 yellow and road-2 red are lit. In 100 only road-1 red and road-2 green are lit. In 101 only road-1 red and road-2 yellow are lit. In 000 and 011 only the two reds are lit.
- R4: In every cycle each road has exactly one lamp lit, and the two greens are never lit together.
- R5: With the request high in any of the six normal phases, the next edge moves the phase to 110.
- R6: In phase 110, a high request keeps the phase at 110 and a low request moves it to 000 on the next edge.
- R7: In phase 110 both red lamps are lit and no green or yellow lamp is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| emerg_req | input | 1 | Emergency request; high forces and holds the all-red phase 110 |
| rd1_red | output | 1 | Road 1 red lamp |
| rd1_yel | output | 1 | Road 1 yellow lamp |
| rd1_grn | output | 1 | Road 1 green lamp |
| rd2_red | output | 1 | Road 2 red lamp |
| rd2_yel | output | 1 | Road 2 yellow lamp |
| rd2_grn | output | 1 | Road 2 green lamp |
| phase | output | 3 | Current phase code |

## Verification
The phase code is visible at the ports, so a wrong next-state term shows up as a wrong code one edge after the faulty phase. It also shows up in the lamps in that same cycle, because they decode the register with no extra delay. A lamp fault is seen in the cycle of the phase that selects it, and a missing or extra term in a red OR shows up as a road with zero or two lamps lit. Stepping every phase with the request low and high covers each next-state row and each decoded line at least once.

// File: rtl/tl_pkg.sv
package tl_pkg;
   localparam int STATE_W   = 3;
   localparam int NUM_CODES = 1 << STATE_W;
   localparam int NUM_NORM  = 6;

   localparam logic [STATE_W-1:0] PH_CLEAR_A = 3'b000;
   localparam logic [STATE_W-1:0] PH_GO_1    = 3'b001;
   localparam logic [STATE_W-1:0] PH_WARN_1  = 3'b010;
   localparam logic [STATE_W-1:0] PH_CLEAR_B = 3'b011;
   localparam logic [STATE_W-1:0] PH_GO_2    = 3'b100;
   localparam logic [STATE_W-1:0] PH_WARN_2  = 3'b101;
   localparam logic [STATE_W-1:0] PH_EMERG   = 3'b110;
   localparam logic [STATE_W-1:0] PH_BAD     = 3'b111;

   // A bit per decoded code: set where that road must show red.
   localparam logic [NUM_CODES-1:0] RD1_RED_SET = 8'b1111_1001;
   localparam logic [NUM_CODES-1:0] RD2_RED_SET = 8'b1100_1111;

   typedef struct packed {
      logic red;
      logic yel;
      logic grn;
   } road_lamps_t;
endpackage

// File: rtl/tl_state_reg.sv
module tl_state_reg
   import tl_pkg::*;
#(
   parameter logic [STATE_W-1:0] RESET_CODE = PH_CLEAR_A
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] d,
   output logic [STATE_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= RESET_CODE;
      else     q <= d;
   end
endmodule

// File: rtl/tl_next_phase.sv
module tl_next_phase
   import tl_pkg::*;
#(
   parameter int NEXT_STYLE = 0   // 0: minimized equations, 1: case table
) (
   input  logic [STATE_W-1:0] cur,
   input  logic               req,
   output logic [STATE_W-1:0] nxt
);
   logic [STATE_W-1:0] norm_nxt;
   logic               in_emerg_or_bad;

   assign in_emerg_or_bad = cur[2] & cur[1];

   generate
      if (NEXT_STYLE == 0) begin : g_eqn
         logic a, b, c;
         assign a = cur[2];
         assign b = cur[1];
         assign c = cur[0];
         assign norm_nxt[2] = (b & c) | (a & ~c);
         assign norm_nxt[1] = (b & ~c) | (~a & ~b & c);
         assign norm_nxt[0] = ~c;
      end else begin : g_table
         always_comb begin
            unique case (cur)
               PH_CLEAR_A: norm_nxt = PH_GO_1;
               PH_GO_1:    norm_nxt = PH_WARN_1;
               PH_WARN_1:  norm_nxt = PH_CLEAR_B;
               PH_CLEAR_B: norm_nxt = PH_GO_2;
               PH_GO_2:    norm_nxt = PH_WARN_2;
               default:    norm_nxt = PH_CLEAR_A;
            endcase
         end
      end
   endgenerate

   always_comb begin
      if (req)                  nxt = PH_EMERG;
      else if (in_emerg_or_bad) nxt = PH_CLEAR_A;
      else                      nxt = norm_nxt;
   end
endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
   import tl_pkg::*;
(
   input  logic [STATE_W-1:0] cur,
   output road_lamps_t        rd1,
   output road_lamps_t        rd2
);
   logic [NUM_CODES-1:0] hot;

   generate
      for (genvar j = 0; j < NUM_CODES; j++) begin : g_dec
         assign hot[j] = (cur == STATE_W'(j));
      end
   endgenerate

   assign rd1.grn = hot[PH_GO_1];
   assign rd1.yel = hot[PH_WARN_1];
   assign rd1.red = |(hot & RD1_RED_SET);
   assign rd2.grn = hot[PH_GO_2];
   assign rd2.yel = hot[PH_WARN_2];
   assign rd2.red = |(hot & RD2_RED_SET);
endmodule

// File: rtl/tl_intersection_ctrl.sv
module tl_intersection_ctrl
   import tl_pkg::*;
#(
   parameter int NEXT_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               emerg_req,
   output logic               rd1_red,
   output logic               rd1_yel,
   output logic               rd1_grn,
   output logic               rd2_red,
   output logic               rd2_yel,
   output logic               rd2_grn,
   output logic [STATE_W-1:0] phase
);
   generate
      if (NEXT_STYLE != 0 && NEXT_STYLE != 1) begin : g_bad_style
         $error("tl_intersection_ctrl: NEXT_STYLE must be 0 or 1");
      end
      if (NUM_NORM + 2 != NUM_CODES) begin : g_bad_codes
         $error("tl_intersection_ctrl: code space does not fit six phases plus two");
      end
   endgenerate

   logic [STATE_W-1:0] cur_q, nxt_d;
   road_lamps_t        l1, l2;

   tl_state_reg #(.RESET_CODE(PH_CLEAR_A)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (nxt_d),
      .q   (cur_q)
   );

   tl_next_phase #(.NEXT_STYLE(NEXT_STYLE)) u_next (
      .cur (cur_q),
      .req (emerg_req),
      .nxt (nxt_d)
   );

   tl_lamp_decode u_dec (
      .cur (cur_q),
      .rd1 (l1),
      .rd2 (l2)
   );

   assign rd1_red = l1.red;
   assign rd1_yel = l1.yel;
   assign rd1_grn = l1.grn;
   assign rd2_red = l2.red;
   assign rd2_yel = l2.yel;
   assign rd2_grn = l2.grn;
   assign phase   = cur_q;
endmodule

// File: rtl/tl_intersection_chk.sv
module tl_intersection_chk (
   input logic       clk,
   input logic       rst,
   input logic       emerg_req,
   input logic       rd1_red,
   input logic       rd1_yel,
   input logic       rd1_grn,
   input logic       rd2_red,
   input logic       rd2_yel,
   input logic       rd2_grn,
   input logic [2:0] phase
);
   a_r1_reset_clear: assert property (@(posedge clk)
      rst |=> (phase == 3'b000));

   a_r2_advance: assert property (@(posedge clk) disable iff (rst)
      (!emerg_req && phase < 3'd5) |=> (phase == 3'($past(phase) + 3'd1)));

   a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
      (!emerg_req && phase == 3'd5) |=> (phase == 3'd0));

   a_r4_one_lamp_rd1: assert property (@(posedge clk) disable iff (rst)
      $countones({rd1_red, rd1_yel, rd1_grn}) == 1);

   a_r4_one_lamp_rd2: assert property (@(posedge clk) disable iff (rst)
      $countones({rd2_red, rd2_yel, rd2_grn}) == 1);

   a_r4_no_dual_green: assert property (@(posedge clk) disable iff (rst)
      !(rd1_grn && rd2_grn));

   a_r5_emerg_entry: assert property (@(posedge clk) disable iff (rst)
      emerg_req |=> (phase == 3'b110));

   a_r6_emerg_exit: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'b110 && !emerg_req) |=> (phase == 3'b000));

   a_r7_emerg_all_red: assert property (@(posedge clk) disable iff (rst)
      (phase == 3'b110) |-> (rd1_red && rd2_red && !rd1_grn && !rd2_grn && !rd1_yel && !rd2_yel));
endmodule

bind tl_intersection_ctrl tl_intersection_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .emerg_req (emerg_req),
   .rd1_red   (rd1_red),
   .rd1_yel   (rd1_yel),
   .rd1_grn   (rd1_grn),
   .rd2_red   (rd2_red),
   .rd2_yel   (rd2_yel),
   .rd2_grn   (rd2_grn),
   .phase     (phase)
);

// File: tb/tl_intersection_ctrl_tb.sv
`timescale 1ns/1ps
module tl_intersection_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       emerg_req;
   logic       rd1_red, rd1_yel, rd1_grn;
   logic       rd2_red, rd2_yel, rd2_grn;
   logic [2:0] phase;

   int         checks = 0;
   int         errors = 0;
   logic [2:0] exp_ph;

   always #2 clk = ~clk;

   tl_intersection_ctrl u_dut (
      .clk       (clk),
      .rst       (rst),
      .emerg_req (emerg_req),
      .rd1_red   (rd1_red),
      .rd1_yel   (rd1_yel),
      .rd1_grn   (rd1_grn),
      .rd2_red   (rd2_red),
      .rd2_yel   (rd2_yel),
      .rd2_grn   (rd2_grn),
      .phase     (phase)
   );

   function automatic logic [2:0] model_next(input logic [2:0] s, input logic xv);
      if (xv)         return 3'd6;
      else if (s >= 6) return 3'd0;
      else            return 3'((s + 1) % 6);
   endfunction

   // {rd1 red, yel, grn, rd2 red, yel, grn}
   function automatic logic [5:0] model_lamps(input logic [2:0] s);
      logic [2:0] a, b;
      a = (s == 3'd1) ? 3'b001 : (s == 3'd2) ? 3'b010 : 3'b100;
      b = (s == 3'd4) ? 3'b001 : (s == 3'd5) ? 3'b010 : 3'b100;
      return {a, b};
   endfunction

   task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h phase=%0d", tag, act, expv, exp_ph);
      end
   endtask

   task automatic sample(input string tag);
      logic [5:0] lamps;
      lamps = {rd1_red, rd1_yel, rd1_grn, rd2_red, rd2_yel, rd2_grn};
      chk(tag, {3'b000, phase}, {3'b000, exp_ph});
      if (exp_ph == 3'd6) chk("R7 emergency lamps", lamps, 6'b100_100);
      else                chk("R3 lamp map", lamps, model_lamps(exp_ph));
      chk("R4 one lamp per road, no dual green",
          {3'b000, ($countones(lamps[5:3]) == 1), ($countones(lamps[2:0]) == 1),
           !(rd1_grn && rd2_grn)}, 6'b000_111);
   endtask

   task automatic tick(input logic xv, input string tag);
      emerg_req = xv;
      @(posedge clk);
      if (rst) exp_ph = 3'd0;
      else     exp_ph = model_next(exp_ph, xv);
      @(negedge clk);
      sample(tag);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(1'b0, "R1 reset phase");
      tick(1'b0, "R1 reset phase");
      rst = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst       = 1'b1;
      emerg_req = 1'b0;
      exp_ph    = 3'd0;
      @(negedge clk);
      do_reset();

      // R2: several full cycles with the request low
      for (int n = 0; n < 4 * 6; n++) tick(1'b0, "R2 phase order");

      // R5, R6: request raised in each normal phase in turn
      for (int k = 0; k < 6; k++) begin
         do_reset();
         for (int i = 0; i < k; i++) tick(1'b0, "R2 approach");
         tick(1'b1, "R5 entry");
         for (int h = 0; h < 4; h++) tick(1'b1, "R6 hold");
         tick(1'b0, "R6 exit to 000");
         tick(1'b0, "R2 resume after exit");
      end

      // R6: a one-cycle pulse enters and leaves at once
      tick(1'b1, "R5 pulse entry");
      tick(1'b0, "R6 pulse exit");

      // R1: reset while in emergency
      tick(1'b1, "R5 entry before reset");
      rst = 1'b1;
      tick(1'b1, "R1 reset overrides request");
      rst = 1'b0;
      tick(1'b0, "R2 after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule